// File: doc/BRIEF.md
# Data-Edge Phase Alignment Controller

The block sits in a fast clock domain running at sixteen times the rate of a 16-bit parallel input word and turns that word into a serial stream without any word clock. It oversamples bit 0 of the parallel bus and finds its rising edges. It keeps a free-running phase counter from 0 to 15. On an alignment it stores the counter value seen at the detected edge as the capture phase. From then on it loads the parallel word into a 16:1 shift register once per 16 fast cycles at that phase. The shift register sends the word out least significant bit first.

The first automatic alignment waits for the lock indication. Later alignments happen by themselves when a bit-0 edge lands more than six fast cycles, in either direction, from the stored phase. A user can also force one alignment by holding an active-low adjust input low. The block then realigns on the next bit-0 edge and issues a fixed-width monitor pulse. A further forced alignment is possible only after a reset. After every alignment, an invalid flag marks the first sixteen serial bits.

Top module: `edge_phase_aligner`

## Requirements
- R1: During and after reset, `ser_out`, `adj_mon` and `out_invalid` are 0. `ser_out` stays 0 until the first alignment has been made.
- R2: Let edge k be the first rising clock edge that samples `par_in[0]` high after it was sampled low. If this edge causes an alignment, the word on `par_in` is captured at edges k+2, k+18, k+34 and so on, every 16 edges.
- R3: While `lock_ok` is 0 and `force_adj_n` is 1, no automatic alignment is made. The outputs stay 0.
- R4: Let c be a capture edge. After edge c+j, for j from 0 to 15, `ser_out` equals bit j of the captured word, so the word goes out least significant bit first.
- R5: Let a later bit-0 edge be first sampled at edge k'. Take d = (k' - k) mod 16 as a signed value from -8 to 7, where k is the edge of the last alignment. If d is greater than 6 or less than -6, a realignment is made at k'+2 and the capture phase moves. If d is between -6 and 6, the capture phase is kept and no flag is raised.
- R6: If `force_adj_n` is 0 when a bit-0 edge arrives, an alignment is made even with zero drift. It happens only once: further edges while the input stays low cause nothing.
- R7: Driving `rst_n` low and then high allows one more forced alignment.
- R8: For a forced alignment from edge k, `adj_mon` is 1 after edges k+2 through k+13, which is 12 cycles. It is 0 after edge k+1 and after edge k+14. Automatic alignments leave it at 0.
- R9: After every alignment from edge k, `out_invalid` is 1 after edges k+2 through k+17, which are the 16 serial bits of the first word. It is 0 otherwise.
- R10: While `ext_clk_mode` is 1, bit-0 edges are ignored. No alignment is made and no monitor pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_mode | input | 1 | 1 = externally clocked mode, edge alignment disabled; 0 = edge-derived mode |
| lock_ok | input | 1 | Lock indication; gates the first automatic alignment |
| force_adj_n | input | 1 | Active-low forced-alignment request |
| par_in | input | 16 | Parallel input word; bit 0 carries the reference edges |
| ser_out | output | 1 | Serial data output, least significant bit first |
| adj_mon | output | 1 | Pulse reporting a forced alignment |
| out_invalid | output | 1 | High while the first word after an alignment is shifted out |

## Verification
Every result is counted in clock edges from edge k, the first edge that samples bit 0 high. The capture, the rise of the monitor and the rise of the invalid flag all come at edge k+2. The monitor falls after k+13 and the invalid flag after k+17. Serial bit j appears after capture edge plus j. The bench keeps a running edge count and samples at the falling edge just after the edge it is waiting for. It creates each drift offset by choosing the cycle in which bit 0 rises, modulo 16, relative to the last alignment edge. The expected pulse windows and the serial bits at the old or new capture phase then follow directly from that offset.

// File: rtl/pa_pkg.sv
`timescale 1ns/1ps
package pa_pkg;
    localparam int unsigned PA_WORD_W    = 16;
    localparam int unsigned PA_SYNC_N    = 2;
    localparam int unsigned PA_DRIFT_MAX = 6;
    localparam int unsigned PA_MON_LEN   = 12;

    typedef enum logic [1:0] {
        ALN_NONE,
        ALN_INIT,
        ALN_DRIFT,
        ALN_FORCE
    } align_src_e;
endpackage

// File: rtl/pa_edge_sync.sv
`timescale 1ns/1ps
module pa_edge_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC_N:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[SYNC_N-1:0], din};
        rise   = pipe_q[SYNC_N-1] & ~pipe_q[SYNC_N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2
endmodule

// File: rtl/pa_align_ctrl.sv
`timescale 1ns/1ps
module pa_align_ctrl import pa_pkg::*; #(
    parameter int unsigned WORD_W    = PA_WORD_W,
    parameter int unsigned DRIFT_MAX = PA_DRIFT_MAX,
    parameter int unsigned MON_LEN   = PA_MON_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_seen,
    input  logic ext_clk_mode,
    input  logic lock_ok,
    input  logic force_adj_n,
    output logic load_word,
    output logic aligned,
    output logic adj_mon,
    output logic out_invalid
);
    localparam int unsigned PH_W  = $clog2(WORD_W);
    localparam int unsigned MON_W = $clog2(MON_LEN + 1);
    localparam int unsigned INV_W = $clog2(WORD_W + 1);
    localparam logic signed [PH_W-1:0] DRIFT_LIM = PH_W'(DRIFT_MAX);

    typedef struct packed {
        logic [PH_W-1:0]  ph_cnt;
        logic [PH_W-1:0]  lock_ph;
        logic             aligned;
        logic             force_spent;
        logic [MON_W-1:0] mon_cnt;
        logic [INV_W-1:0] inv_cnt;
    } ctl_t;

    ctl_t                   st_d, st_q;
    align_src_e             src;
    logic signed [PH_W-1:0] drift;
    logic                   drift_hi;
    logic                   armed;

    always_comb begin
        st_d        = st_q;
        st_d.ph_cnt = st_q.ph_cnt + 1'b1;
        drift       = $signed(st_q.ph_cnt - st_q.lock_ph);
        drift_hi    = (drift > DRIFT_LIM) || (drift < -DRIFT_LIM);
        armed       = edge_seen && !ext_clk_mode;

        src = ALN_NONE;
        if (armed) begin
            if (!force_adj_n && !st_q.force_spent) src = ALN_FORCE;
            else if (!st_q.aligned && lock_ok)     src = ALN_INIT;
            else if (st_q.aligned && drift_hi)     src = ALN_DRIFT;
        end

        if (st_q.mon_cnt != '0) st_d.mon_cnt = st_q.mon_cnt - 1'b1;
        if (st_q.inv_cnt != '0) st_d.inv_cnt = st_q.inv_cnt - 1'b1;

        if (src != ALN_NONE) begin
            st_d.lock_ph = st_q.ph_cnt;
            st_d.aligned = 1'b1;
            st_d.inv_cnt = INV_W'(WORD_W);
        end
        if (src == ALN_FORCE) begin
            st_d.force_spent = 1'b1;
            st_d.mon_cnt     = MON_W'(MON_LEN);
        end

        load_word = (src != ALN_NONE) ||
                    (st_q.aligned && (st_q.ph_cnt == st_q.lock_ph));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign aligned     = st_q.aligned;
    assign adj_mon     = (st_q.mon_cnt != '0);
    assign out_invalid = (st_q.inv_cnt != '0);

    logic [MON_W:0] mon_run_q;
    logic           mon_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_run_q  <= '0;
            mon_seen_q <= 1'b0;
        end else begin
            mon_run_q  <= adj_mon ? mon_run_q + 1'b1 : '0;
            mon_seen_q <= mon_seen_q | adj_mon;
        end
    end

    AST_MON_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adj_mon) |-> (mon_run_q == (MON_W+1)'(MON_LEN))); // R8
    AST_FORCE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adj_mon) |-> !mon_seen_q); // R6
    AST_INV_ON_MON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adj_mon) |-> out_invalid); // R9
    AST_LOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!aligned && !lock_ok && force_adj_n) |=> !aligned); // R3
    AST_EXT_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clk_mode && !aligned) |=> !aligned); // R10
endmodule

// File: rtl/pa_serializer.sv
`timescale 1ns/1ps
module pa_serializer #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              ser
);
    logic [WORD_W-1:0] shf_d, shf_q;

    always_comb begin
        shf_d = load ? word : (shf_q >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign ser = shf_q[0];
endmodule

// File: rtl/edge_phase_aligner.sv
`timescale 1ns/1ps
module edge_phase_aligner import pa_pkg::*; #(
    parameter int unsigned WORD_W    = PA_WORD_W,
    parameter int unsigned SYNC_N    = PA_SYNC_N,
    parameter int unsigned DRIFT_MAX = PA_DRIFT_MAX,
    parameter int unsigned MON_LEN   = PA_MON_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_mode,
    input  logic              lock_ok,
    input  logic              force_adj_n,
    input  logic [WORD_W-1:0] par_in,
    output logic              ser_out,
    output logic              adj_mon,
    output logic              out_invalid
);
    logic rise;
    logic load_word;
    logic aligned;

    pa_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (par_in[0]),
        .rise (rise)
    );

    pa_align_ctrl #(
        .WORD_W   (WORD_W),
        .DRIFT_MAX(DRIFT_MAX),
        .MON_LEN  (MON_LEN)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_seen   (rise),
        .ext_clk_mode(ext_clk_mode),
        .lock_ok     (lock_ok),
        .force_adj_n (force_adj_n),
        .load_word   (load_word),
        .aligned     (aligned),
        .adj_mon     (adj_mon),
        .out_invalid (out_invalid)
    );

    pa_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load_word),
        .word (par_in),
        .ser  (ser_out)
    );

    AST_SER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> !ser_out); // R1
endmodule

// File: tb/tb_edge_phase_aligner.sv
`timescale 1ns/1ps
module tb_edge_phase_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_mode = 1'b0;
    logic        lock_ok = 1'b0;
    logic        force_adj_n = 1'b1;
    logic [15:0] par_in = '0;
    logic        ser_out, adj_mon, out_invalid;

    int cyc = 0;
    int kref = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // table: bit 16 = expected invalid flag for the frame, bits 15:0 = word (bit 0 kept high)
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        17'h1_A5A5, 17'h0_0001, 17'h0_8001, 17'h0_FFFF, 17'h0_1235, 17'h0_7FFF
    };

    edge_phase_aligner dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_mode(ext_clk_mode), .lock_ok(lock_ok),
        .force_adj_n(force_adj_n), .par_in(par_in), .ser_out(ser_out),
        .adj_mon(adj_mon), .out_invalid(out_invalid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mod16(input int v);
        return ((v % 16) + 16) % 16;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic wait_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic make_edge(input int d, output int k);
        par_in[0] = 1'b0;
        repeat (3) @(negedge clk);
        while (mod16(cyc + 1 - kref) != d) @(negedge clk);
        par_in[0] = 1'b1;
        k = cyc + 1;
    endtask

    task automatic watch_align(input int k, input bit forced, input string rq);
        for (int e = k + 1; e <= k + 18; e++) begin
            wait_to(e);
            chk({rq, " R8 monitor"}, adj_mon, (forced && e >= k + 2 && e <= k + 13) ? 1 : 0);
            chk({rq, " R9 invalid"}, out_invalid, (e >= k + 2 && e <= k + 17) ? 1 : 0);
        end
    endtask

    task automatic watch_quiet(input int k, input string rq);
        for (int e = k + 1; e <= k + 18; e++) begin
            wait_to(e);
            chk({rq, " monitor quiet"}, adj_mon, 0);
            chk({rq, " invalid quiet"}, out_invalid, 0);
        end
    endtask

    task automatic cap_check(input logic [15:0] w, input string rq);
        while (mod16(cyc + 1 - kref - 2) != 0) @(negedge clk);
        par_in = w;
        for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            chk({rq, " R4 serial bit"}, ser_out, w[j]);
        end
    endtask

    initial begin
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ser_out in reset", ser_out, 0);
        chk("R1 adj_mon in reset", adj_mon, 0);
        chk("R1 out_invalid in reset", out_invalid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: edges without lock make no alignment
        for (int i = 0; i < 40; i++) begin
            par_in = (i % 5 < 2) ? 16'hFFFF : 16'h0000;
            @(negedge clk);
            if (i % 8 == 7) begin
                chk("R3 ser_out without lock", ser_out, 0);
                chk("R3 invalid without lock", out_invalid, 0);
            end
        end

        // R10: externally clocked mode ignores edges
        ext_clk_mode = 1'b1;
        lock_ok = 1'b1;
        force_adj_n = 1'b0;
        for (int i = 0; i < 40; i++) begin
            par_in = (i % 6 < 3) ? 16'hFFFF : 16'h0000;
            @(negedge clk);
            if (i % 8 == 7) begin
                chk("R10 ser_out in ext mode", ser_out, 0);
                chk("R10 monitor in ext mode", adj_mon, 0);
                chk("R10 invalid in ext mode", out_invalid, 0);
            end
        end
        force_adj_n = 1'b1;
        par_in = 16'h0000;
        repeat (5) @(negedge clk);
        ext_clk_mode = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 ser_out before first alignment", ser_out, 0);

        // R2/R4/R9: first alignment, then walk the vector table
        par_in = {VEC[0][15:1], 1'b0};
        make_edge(0, k);
        kref = k;
        wait_to(k + 1);
        chk("R2 no capture before k+2", out_invalid, 0);
        wait_to(k + 2);
        for (int i = 0; i < NV; i++) begin
            for (int j = 0; j < 16; j++) begin
                chk("R2 R4 table serial bit", ser_out, VEC[i][j]);
                chk("R9 table invalid flag", out_invalid, VEC[i][16]);
                chk("R8 no monitor on auto alignment", adj_mon, 0);
                if (j == 0 && i + 1 < NV) par_in = VEC[i + 1][15:0];
                @(negedge clk);
            end
        end

        // R5: drift of +6 keeps the phase
        make_edge(6, k);
        watch_quiet(k, "R5 drift +6");
        cap_check(16'hC3C5, "R5 phase kept after +6");

        // R5: drift of +7 realigns
        make_edge(7, k);
        watch_align(k, 0, "R5 drift +7");
        kref = k;
        cap_check(16'h3C3D, "R5 new phase after +7");

        // R5: drift of -6 keeps the phase
        make_edge(10, k);
        watch_quiet(k, "R5 drift -6");
        cap_check(16'h5A5B, "R5 phase kept after -6");

        // R5: drift of -7 realigns
        make_edge(9, k);
        watch_align(k, 0, "R5 drift -7");
        kref = k;
        cap_check(16'h9669, "R5 new phase after -7");

        // R6/R8: forced alignment with zero drift, then only once
        force_adj_n = 1'b0;
        make_edge(0, k);
        watch_align(k, 1, "R6 forced");
        kref = k;
        make_edge(0, k);
        watch_quiet(k, "R6 second edge while low");
        force_adj_n = 1'b1;
        cap_check(16'hE7E7, "R6 phase after forced");

        // R7: reset re-arms the forced alignment
        par_in = 16'h0000;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ser_out after reset", ser_out, 0);
        chk("R1 monitor after reset", adj_mon, 0);
        chk("R1 invalid after reset", out_invalid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ser_out unaligned after reset", ser_out, 0);
        make_edge(0, k);
        watch_align(k, 0, "R7 auto after reset");
        kref = k;
        force_adj_n = 1'b0;
        make_edge(0, k);
        watch_align(k, 1, "R7 forced re-armed");
        kref = k;
        force_adj_n = 1'b1;
        cap_check(16'h0FF1, "R7 phase after re-armed force");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule